// File: doc/BRIEF.md
# Big-Endian Word Load/Store Unit

This unit connects a 32-bit register datapath to a byte-addressed data memory and performs whole-word loads and stores. For each request it adds a sign-extended 16-bit byte displacement to a base register value, which gives the effective address. It then checks that this address lies on a 4-byte boundary. Only aligned requests reach the memory.

The register word is big-endian: its most significant byte belongs to the lowest byte address. The memory bus is little-lane: lane k carries the byte at address+k. The unit therefore reverses the byte lanes in both directions. A store writes all four lanes in one cycle. A load returns its result one cycle after the request, because the memory read is synchronous.

An array element with index i sits at byte displacement 4*i from the array base. A request whose effective address is misaligned is dropped, and the unit raises a one-cycle error flag instead.

Top module: `be_word_lsu`

## Requirements
- R1: The effective address equals base_i plus offset_i sign-extended to 32 bits, modulo 2^32. On an aligned request mem_addr_o carries this address in the same cycle.
- R2: A request is aligned only when effective address bits 1:0 are 00. mem_req_o is high in a cycle only when req_i is high and the address is aligned.
- R3: On a misaligned request misalign_o is high in the following cycle only. No memory access is issued, rvalid_o stays low, and memory contents are left unchanged.
- R4: An aligned store (op_i=1) drives mem_we_o=1 and mem_be_o=4'b1111. Lane k of mem_wdata_o (bits 8k+7:8k) carries the register byte destined for address+k, so wdata_i[31:24] goes on lane 0 and wdata_i[7:0] goes on lane 3.
- R5: An aligned load (op_i=0) raises rvalid_o in the next cycle. In that cycle rdata_o[31:24] holds the byte at the effective address and rdata_o[7:0] holds the byte at address+3.
- R6: After reset, and in any cycle without a load result, rvalid_o, misalign_o and rdata_o are zero. With no request, mem_req_o, mem_we_o and mem_be_o are zero.
- R7: Words at consecutive indices lie 4 byte addresses apart. Stores at displacements 32 and 48 from one base land in separate words, and each can be read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request |
| op_i | input | 1 | 0 = load, 1 = store |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed byte displacement |
| wdata_i | input | 32 | Store data (register word) |
| rdata_o | output | 32 | Load result |
| rvalid_o | output | 1 | Load result valid |
| misalign_o | output | 1 | Misaligned request flag |
| mem_req_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | 4 | Byte-lane write strobes |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data, lane k = address+k |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read |

## Verification
The assertions assume that the memory returns read data exactly one cycle after an accepted read. They also assume that the operation input is a clean 0 or 1 whenever req_i is high.

The bench's memory model is a synchronous byte array with that exact latency. The bench drives every input at the falling clock edge with defined values. Its stimulus covers negative displacements, address wrap past 2^32, all three misaligned residues, and back-to-back and idle cycles. All of these stay inside the assumed memory contract.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  typedef enum logic {
    LSU_LOAD  = 1'b0,
    LSU_STORE = 1'b1
  } lsu_op_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANES  = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              aligned_o
);
  localparam int LSB_W = $clog2(LANES);

  logic [ADDR_W-1:0] off_sext;

  always_comb begin
    off_sext  = {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
    ea_o      = base_i + off_sext;  // wraps modulo 2^ADDR_W
    aligned_o = (ea_o[LSB_W-1:0] == '0);
  end
endmodule

// File: rtl/lsu_lane_swap.sv
module lsu_lane_swap #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic [LANES*BYTE_W-1:0] in_i,
  output logic [LANES*BYTE_W-1:0] out_o
);
  // register msb byte <-> lowest address lane; self-inverse
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign out_o[k*BYTE_W +: BYTE_W] = in_i[(LANES-1-k)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/lsu_resp.sv
module lsu_resp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_fire_i,
  input  logic bad_fire_i,
  output logic rvalid_o,
  output logic misalign_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o   <= 1'b0;
      misalign_o <= 1'b0;
    end else begin
      rvalid_o   <= load_fire_i;
      misalign_o <= bad_fire_i;
    end
  end

  AST_FLAG_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rvalid_o && misalign_o)); // R3
endmodule

// File: rtl/be_word_lsu.sv
module be_word_lsu
  import be_lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     op_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [OFF_W-1:0]         offset_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  output logic                     misalign_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [DATA_W/BYTE_W-1:0] mem_be_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  input  logic [DATA_W-1:0]        mem_rdata_i
);
  localparam int LANES = DATA_W / BYTE_W;
  localparam int LSB_W = $clog2(LANES);

  lsu_op_e           op;
  logic [ADDR_W-1:0] ea;
  logic              aligned;
  logic [DATA_W-1:0] rd_swapped;

  assign op = lsu_op_e'(op_i);

  lsu_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANES(LANES)) u_agen (
    .base_i    (base_i),
    .offset_i  (offset_i),
    .ea_o      (ea),
    .aligned_o (aligned)
  );

  lsu_lane_swap #(.LANES(LANES), .BYTE_W(BYTE_W)) u_wr_swap (
    .in_i  (wdata_i),
    .out_o (mem_wdata_o)
  );

  lsu_lane_swap #(.LANES(LANES), .BYTE_W(BYTE_W)) u_rd_swap (
    .in_i  (mem_rdata_i),
    .out_o (rd_swapped)
  );

  always_comb begin
    mem_req_o  = req_i && aligned;
    mem_we_o   = mem_req_o && (op == LSU_STORE);
    mem_be_o   = mem_we_o ? '1 : '0;
    mem_addr_o = ea;
  end

  lsu_resp u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_fire_i (mem_req_o && (op == LSU_LOAD)),
    .bad_fire_i  (req_i && !aligned),
    .rvalid_o    (rvalid_o),
    .misalign_o  (misalign_o)
  );

  assign rdata_o = rvalid_o ? rd_swapped : '0;

  AST_MEM_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[LSB_W-1:0] == '0)); // R2
  AST_WRITE_FULL_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && mem_be_o == '1)); // R4
  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(mem_req_o && !mem_we_o)); // R5
  AST_MISALIGN_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> $past(req_i && !mem_req_o)); // R3
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0)); // R6
endmodule

// File: tb/be_word_lsu_tb_top.sv
`timescale 1ns/1ps
module be_word_lsu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, op = 1'b0;
  logic [31:0] base = '0, wdata = '0;
  logic [15:0] offset = '0;
  logic [31:0] rdata, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rvalid, misalign, mem_req, mem_we;
  logic [3:0]  mem_be;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] ram [256];
  logic [7:0] ref_mem [256];

  always #10 clk = ~clk;  // 50 MHz

  be_word_lsu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .base_i(base),
    .offset_i(offset), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .misalign_o(misalign), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_be_o(mem_be), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  // synchronous byte memory, lane k = address+k
  always @(posedge clk) begin
    if (mem_req) begin
      for (int k = 0; k < 4; k++) begin
        if (mem_we && mem_be[k]) ram[8'(mem_addr[7:0] + k)] <= mem_wdata[k*8 +: 8];
        mem_rdata[k*8 +: 8] <= ram[8'(mem_addr[7:0] + k)];
      end
    end
  end

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  function automatic logic [31:0] be_word(logic [7:0] a);
    return {ref_mem[a], ref_mem[8'(a + 1)], ref_mem[8'(a + 2)], ref_mem[8'(a + 3)]};
  endfunction

  // one request: drive at negedge, check memory side, then next-cycle outputs
  task automatic step(bit rq, bit st, logic [31:0] b, logic [15:0] off, logic [31:0] wd);
    logic [31:0] ea, exp_rd, lanes;
    bit ok, exp_v, exp_m;
    req = rq; op = st; base = b; offset = off; wdata = wd;
    ea = b + {{16{off[15]}}, off};
    ok = (ea[1:0] == 2'b00);
    for (int k = 0; k < 4; k++) lanes[k*8 +: 8] = wd[31 - 8*k -: 8];
    #1;
    chk("R2", "mem_req", 32'(mem_req), 32'(rq && ok));
    chk("R4", "mem_we", 32'(mem_we), 32'(rq && ok && st));
    chk("R4", "mem_be", 32'(mem_be), (rq && ok && st) ? 32'hF : 32'h0);
    if (rq && ok) chk("R1", "mem_addr", mem_addr, ea);
    if (rq && ok && st) chk("R4", "mem_wdata", mem_wdata, lanes);
    exp_v  = rq && ok && !st;
    exp_m  = rq && !ok;
    exp_rd = exp_v ? be_word(ea[7:0]) : 32'h0;
    if (rq && ok && st)
      for (int k = 0; k < 4; k++) ref_mem[8'(ea[7:0] + k)] = wd[31 - 8*k -: 8];
    @(posedge clk);
    @(negedge clk);
    chk("R5", "rvalid", 32'(rvalid), 32'(exp_v));
    chk("R3", "misalign", 32'(misalign), 32'(exp_m));
    chk(exp_v ? "R5" : "R6", "rdata", rdata, exp_rd);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R6 reset state
    chk("R6", "rvalid reset", 32'(rvalid), 0);
    chk("R6", "misalign reset", 32'(misalign), 0);
    chk("R6", "rdata reset", rdata, 0);
    chk("R6", "mem_req idle", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 plain loads of initial contents
    step(1, 0, 32'h40, 16'h0000, 0);
    step(1, 0, 32'h40, 16'h0004, 0);
    // R4 store then load back
    step(1, 1, 32'h40, 16'h0008, 32'h1122_3344);
    step(1, 0, 32'h40, 16'h0008, 0);
    // R1 negative displacement
    step(1, 1, 32'h80, 16'hFFFC, 32'hDEAD_BEEF);
    step(1, 0, 32'h7C, 16'h0000, 0);
    // R1 wrap past 2^32
    step(1, 1, 32'hFFFF_FFF8, 16'h0010, 32'hA5A5_0F0F);
    step(1, 0, 32'h0000_0000, 16'h0008, 0);
    // R3 misaligned residues, load and store; memory untouched
    step(1, 1, 32'h40, 16'h0009, 32'hFFFF_FFFF);
    step(1, 1, 32'h42, 16'h0008, 32'hFFFF_FFFF);
    step(1, 0, 32'h40, 16'h000B, 0);
    step(1, 0, 32'h41, 16'hFFFF, 0);   // ea=0x40, aligned via negative
    step(1, 0, 32'h40, 16'h0008, 0);   // R3 still 11223344
    step(1, 0, 32'h40, 16'h000C, 0);
    // R7 array elements 8 and 12
    step(1, 1, 32'h20, 16'd32, 32'h0807_0605);
    step(1, 1, 32'h20, 16'd48, 32'h0C0B_0A09);
    step(0, 0, 0, 0, 0);
    step(1, 0, 32'h20, 16'd32, 0);
    step(1, 0, 32'h20, 16'd48, 0);
    step(1, 0, 32'h20, 16'd36, 0);
    // R6 idle
    step(0, 1, 32'h44, 16'h0000, 32'h1234_5678);
    // back-to-back mixed traffic
    for (int i = 0; i < 40; i++)
      step(1, i[0], 32'(i * 13), 16'(i * 3), 32'h9E37_79B9 * 32'(i + 1));
    for (int i = 0; i < 64; i++)
      step(1, 0, 32'(i * 4), 16'h0000, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule